// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block gives a processor a read-only view of a serial NOR flash. A bus read carries a byte offset and a length of one to four bytes. The engine picks the setup word of the currently claimed chip select and selects that chip. It shifts out the read opcode, then the offset as a configurable number of address bytes, then runs a configurable number of dummy bytes. It then gathers the requested data on one, two or four lanes and answers with a single 32-bit response word.

Software programs one setup word per chip select. It names the claimed chip select in a separate register and opens the window with a mode-switch bit. While the switch is clear, the window stays closed and every read is refused with an error, so register-driven command traffic can own the pins. A read that would run past the end of the mapped window is also refused, and no flash cycle is started for it. Only one read is in flight at a time. The read port holds off further requests with a ready signal until the response has been returned.

Top module: `flash_mmap_reader`

## Requirements
- R1: After reset all chip selects are high (inactive), `sclk` is low, `rd_ready` is high, `rd_valid` is low and the window switch is closed.
- R2: Configuration writes use `cfg_sel` 0 to 3 for the setup word of chip select 0 to 3. In that word, bits 7:0 hold the opcode, bits 9:8 the address byte count minus one, bits 11:10 the dummy byte count and bits 13:12 the lane mode. `cfg_sel` 4 bit 0 is the window switch (1 = open). `cfg_sel` 5 bits 1:0 name the claimed chip select. Registers change only on a write.
- R3: The opcode and then the low address bytes of `rd_off` are sent on `io_out[0]` with only `io_oe[0]` set. They go most significant bit first, the most significant address byte first, and the address byte count comes from the setup word (1 to 4 bytes).
- R4: After the address, the engine runs 8 `sclk` periods for each dummy byte, with `io_oe` all zero.
- R5: Data is captured on the rising edge of `sclk` with `io_oe` zero. Lane mode 0 uses `io_in[1]`, mode 1 uses `io_in[1:0]` with `io_in[1]` as the earlier bit, and mode 3 uses `io_in[3:0]` with `io_in[3]` as the earliest bit. Mode 2 behaves as mode 0. Bits of each byte arrive most significant first.
- R6: `rd_len_m1` + 1 bytes are read. The byte at the lowest offset is returned in `rd_data[7:0]` and later bytes in higher byte lanes. Unused upper bytes are zero and `rd_err` is low.
- R7: Exactly one `cs_n` bit, that of the claimed chip select, is low from before the first `sclk` rise until after the last data bit. All are high otherwise. The total number of `sclk` rises is 8 + 8·address bytes + 8·dummy bytes + 8·length / lanes.
- R8: `rd_ready` is low from the accepting edge until the response cycle has passed. A request raised while `rd_ready` is low is ignored.
- R9: A read whose offset plus length exceeds `WIN_BYTES` is answered in the cycle after acceptance with `rd_err` high and `rd_data` zero, and no chip select is asserted. A read ending exactly at `WIN_BYTES` is performed normally.
- R10: While the window switch is closed, every read is answered with `rd_err` high and no flash activity.
- R11: `rd_valid` is high for exactly one cycle per accepted read.
- R12: `sclk` idles low, `io_out` is stable while `sclk` is high, and the setup used for a read is captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req | input | 1 | Window read request |
| rd_off | input | ADDR_W | Byte offset inside the window |
| rd_len_m1 | input | 2 | Read length in bytes minus one |
| rd_ready | output | 1 | Engine idle, request will be accepted |
| rd_valid | output | 1 | Response valid for one cycle |
| rd_err | output | 1 | Read refused (window closed or out of range) |
| rd_data | output | 32 | Read data, little-endian |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 4 | Active-low chip selects |
| io_out | output | 4 | Data lanes driven to the flash |
| io_oe | output | 4 | Output enables for the data lanes |
| io_in | input | 4 | Data lanes sampled from the flash |

## Verification
The hardest case to reach is a read that is refused or ignored while everything else looks normal. Examples are a request raised in the middle of a long four-byte-address, three-dummy-byte sequence, or a read that ends one byte past the window edge. The bench holds a flash model that decodes opcode, address and dummy phase from the pins and serves data computed from the address. It raises a second request with a different offset during every busy period, so that any accidental acceptance corrupts the returned data. Random setups cover all lane modes, including the unused mode code. They are mixed with directed reads at the exact window edge and with the switch closed.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int NUM_CS = 4;

    typedef enum logic [1:0] {
        LANE_1 = 2'd0,
        LANE_2 = 2'd1,
        LANE_4 = 2'd2
    } lane_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] nab_m1;
        logic [1:0] dummy;
        lane_e      lanes;
    } setup_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DUMMY,
        S_DATA,
        S_RESP
    } seq_e;

    function automatic setup_t decode_setup(input logic [31:0] w);
        setup_t s;
        s.opcode = w[7:0];
        s.nab_m1 = w[9:8];
        s.dummy  = w[11:10];
        case (w[13:12])
            2'd1:    s.lanes = LANE_2;
            2'd3:    s.lanes = LANE_4;
            default: s.lanes = LANE_1;
        endcase
        return s;
    endfunction

    function automatic logic [5:0] lane_step(input lane_e l);
        case (l)
            LANE_2:  return 6'd2;
            LANE_4:  return 6'd4;
            default: return 6'd1;
        endcase
    endfunction

    function automatic logic [31:0] le_pack(input logic [31:0] rx, input logic [1:0] lm1);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            if (i <= int'(lm1)) r[8*i +: 8] = rx[8*(int'(lm1) - i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/fr_cfg.sv
module fr_cfg
    import fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        mm_en,
    output logic [1:0]  cur_cs,
    output setup_t      cur_setup
);

    setup_t setup_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
        always_ff @(posedge clk) begin
            if (rst) begin
                setup_q[g] <= '0;
            end else if (cfg_we && cfg_sel == 3'(g)) begin
                setup_q[g] <= decode_setup(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_en  <= 1'b0;
            cur_cs <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == 3'd4) mm_en  <= cfg_wdata[0];
            if (cfg_sel == 3'd5) cur_cs <= cfg_wdata[1:0];
        end
    end

    assign cur_setup = setup_q[cur_cs];

    // R2
    sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(mm_en) && $stable(cur_cs));

endmodule

// File: rtl/fr_engine.sv
module fr_engine
    import fr_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int unsigned WIN_BYTES = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mm_en,
    input  logic [1:0]        cur_cs,
    input  setup_t            cur_setup,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_off,
    input  logic [1:0]        rd_len_m1,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [31:0]       rd_data,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    localparam int TX_W = 40;

    seq_e             state;
    logic             phase;
    logic [TX_W-1:0]  tx_sh;
    logic [5:0]       cnt;
    lane_e            lanes_q;
    logic [1:0]       len_q;
    logic [1:0]       dum_q;
    logic [1:0]       cs_q;
    logic [31:0]      rx_sh;
    logic [31:0]      rx_next;
    logic [31:0]      rsp_data;
    logic             rsp_err;
    logic             active;
    logic             win_over;
    logic [31:0]      addr_al;
    logic [5:0]       step;
    logic [5:0]       data_bits;
    logic [32:0]      end_pos;

    assign end_pos  = 33'(rd_off) + 33'(rd_len_m1) + 33'd1;
    assign win_over = end_pos > 33'(WIN_BYTES);
    assign addr_al  = 32'(rd_off) << {2'd3 - cur_setup.nab_m1, 3'b000};
    assign step      = lane_step(lanes_q);
    assign data_bits = {3'({1'b0, len_q}) + 3'd1, 3'b000};

    always_comb begin
        case (lanes_q)
            LANE_2:  rx_next = {rx_sh[29:0], io_in[1:0]};
            LANE_4:  rx_next = {rx_sh[27:0], io_in[3:0]};
            default: rx_next = {rx_sh[30:0], io_in[1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            phase    <= 1'b0;
            tx_sh    <= '0;
            cnt      <= '0;
            lanes_q  <= LANE_1;
            len_q    <= '0;
            dum_q    <= '0;
            cs_q     <= '0;
            rx_sh    <= '0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (rd_req) begin
                    rsp_data <= '0;
                    rx_sh    <= '0;
                    phase    <= 1'b0;
                    len_q    <= rd_len_m1;
                    if (!mm_en || win_over) begin
                        rsp_err <= 1'b1;
                        state   <= S_RESP;
                    end else begin
                        rsp_err <= 1'b0;
                        tx_sh   <= {cur_setup.opcode, addr_al};
                        cnt     <= 6'd16 + {1'b0, cur_setup.nab_m1, 3'b000};
                        dum_q   <= cur_setup.dummy;
                        lanes_q <= cur_setup.lanes;
                        cs_q    <= cur_cs;
                        state   <= S_CMD;
                    end
                end
                S_CMD: begin
                    phase <= ~phase;
                    if (phase) begin
                        tx_sh <= tx_sh << 1;
                        if (cnt == 6'd1) begin
                            if (dum_q != 2'd0) begin
                                state <= S_DUMMY;
                                cnt   <= {1'b0, dum_q, 3'b000};
                            end else begin
                                state <= S_DATA;
                                cnt   <= data_bits;
                            end
                        end else begin
                            cnt <= cnt - 6'd1;
                        end
                    end
                end
                S_DUMMY: begin
                    phase <= ~phase;
                    if (phase) begin
                        if (cnt == 6'd1) begin
                            state <= S_DATA;
                            cnt   <= data_bits;
                        end else begin
                            cnt <= cnt - 6'd1;
                        end
                    end
                end
                S_DATA: begin
                    phase <= ~phase;
                    if (phase) begin
                        rx_sh <= rx_next;
                        if (cnt == step) begin
                            state    <= S_RESP;
                            rsp_data <= le_pack(rx_next, len_q);
                        end else begin
                            cnt <= cnt - step;
                        end
                    end
                end
                S_RESP:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign active = (state == S_CMD) || (state == S_DUMMY) || (state == S_DATA);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(active && cs_q == 2'(g));
    end

    assign sclk     = active && phase;
    assign io_out   = {3'b000, tx_sh[TX_W-1]};
    assign io_oe    = (state == S_CMD) ? 4'b0001 : 4'b0000;
    assign rd_ready = (state == S_IDLE);
    assign rd_valid = (state == S_RESP);
    assign rd_err   = rsp_err;
    assign rd_data  = rsp_data;

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R4
    dummy_float_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DUMMY || state == S_DATA) |-> io_oe == 4'b0000);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> !rd_ready);

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R12
    tx_stable_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(io_out));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_err) |-> rd_data == 32'd0);

endmodule

// File: rtl/flash_mmap_reader.sv
module flash_mmap_reader
    import fr_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int unsigned WIN_BYTES = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_off,
    input  logic [1:0]        rd_len_m1,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [31:0]       rd_data,
    output logic              sclk,
    output logic [3:0]        cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    logic   mm_en;
    logic [1:0] cur_cs;
    setup_t cur_setup;

    fr_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mm_en     (mm_en),
        .cur_cs    (cur_cs),
        .cur_setup (cur_setup)
    );

    fr_engine #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .mm_en     (mm_en),
        .cur_cs    (cur_cs),
        .cur_setup (cur_setup),
        .rd_req    (rd_req),
        .rd_off    (rd_off),
        .rd_len_m1 (rd_len_m1),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err),
        .rd_data   (rd_data),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .io_in     (io_in)
    );

endmodule

// File: tb/flash_mmap_reader_tb.sv
module flash_mmap_reader_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 24;
    localparam int unsigned WIN        = 32'h00F0_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_off = '0;
    logic [1:0]        rd_len_m1 = '0;
    logic              rd_ready, rd_valid, rd_err, sclk;
    logic [31:0]       rd_data;
    logic [3:0]        cs_n, io_out, io_oe;
    logic [3:0]        io_in = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_mmap_reader #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_req(rd_req), .rd_off(rd_off), .rd_len_m1(rd_len_m1),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd37 + 32'd11;
        return t[7:0] ^ a[15:8];
    endfunction

    // flash model
    logic        cs_idle;
    int          edge_cnt = 0, last_edges = 0, frames = 0, oe_bad = 0;
    int          m_nab = 1, m_hdr = 16, m_lanes = 1;
    logic [7:0]  op_rx = '0;
    logic [31:0] adr_rx = '0;
    logic [3:0]  seen_csn = 4'hF;
    assign cs_idle = &cs_n;

    always @(posedge sclk or posedge cs_idle) begin
        if (cs_idle) begin
            if (edge_cnt != 0) begin
                last_edges = edge_cnt;
                frames++;
            end
            edge_cnt = 0;
        end else begin
            if (edge_cnt == 0) begin
                op_rx  = '0;
                adr_rx = '0;
            end
            seen_csn = cs_n;
            if (edge_cnt < 8) begin
                op_rx = {op_rx[6:0], io_out[0]};
                if (io_oe != 4'b0001) oe_bad++;
            end else if (edge_cnt < 8 + 8*m_nab) begin
                adr_rx = {adr_rx[30:0], io_out[0]};
                if (io_oe != 4'b0001) oe_bad++;
            end else if (io_oe != 4'b0000) begin
                oe_bad++;
            end
            edge_cnt++;
        end
    end

    always @(negedge sclk) begin
        if (!cs_idle && edge_cnt >= m_hdr) begin
            int d;
            logic [7:0] b, sh;
            d  = (edge_cnt - m_hdr) * m_lanes;
            b  = mem_byte(adr_rx + 32'(d / 8));
            sh = b << (d % 8);
            case (m_lanes)
                2:       io_in = {2'b00, sh[7:6]};
                4:       io_in = sh[7:4];
                default: io_in = {2'b00, sh[7], 1'b0};
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] off, input logic [1:0] lm1,
                           input bit poke, output logic [31:0] d, output logic e);
        int n;
        @(negedge clk);
        rd_req = 1'b1; rd_off = off; rd_len_m1 = lm1;
        @(negedge clk);
        rd_req = 1'b0;
        n = 0;
        while (!rd_valid && n < 3000) begin
            if (poke && n == 2) begin
                rd_req = 1'b1;
                rd_off = off ^ 24'h05A5A5;
                // R8: busy engine reports not ready
                chk(rd_ready == 1'b0, "R8", 32'(rd_ready), 32'd0);
            end else begin
                rd_req = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        rd_req = 1'b0;
        if (n >= 3000) chk(1'b0, "R11 response timeout", 32'(n), 32'd0);
        d = rd_data;
        e = rd_err;
        @(negedge clk);
        // R11: one-cycle response
        chk(rd_valid == 1'b0 && rd_ready == 1'b1, "R11", 32'(rd_valid), 32'd0);
    endtask

    task automatic good_read(input logic [1:0] cs, input logic [7:0] op, input logic [1:0] nab_m1,
                             input logic [1:0] dum, input logic [1:0] mode,
                             input logic [ADDR_W-1:0] off, input logic [1:0] lm1);
        logic [31:0] d, exp_d, exp_a, mask;
        logic e;
        int fr0, nb;
        cfg_write(3'(cs), {18'd0, mode, dum, nab_m1, op});
        cfg_write(3'd5, 32'(cs));
        m_nab   = int'(nab_m1) + 1;
        m_lanes = (mode == 2'd1) ? 2 : (mode == 2'd3) ? 4 : 1;
        m_hdr   = 8 + 8*m_nab + 8*int'(dum);
        nb      = int'(lm1) + 1;
        mask    = (m_nab == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*m_nab)) - 32'd1);
        exp_a   = 32'(off) & mask;
        exp_d   = '0;
        for (int i = 0; i < nb; i++) exp_d[8*i +: 8] = mem_byte(exp_a + 32'(i));
        fr0    = frames;
        oe_bad = 0;
        do_read(off, lm1, 1'b1, d, e);
        chk(e == 1'b0, "R6 err", 32'(e), 32'd0);
        // R5 R6: lane capture and little-endian packing
        chk(d == exp_d, "R6 data", d, exp_d);
        // R3: opcode and address
        chk(op_rx == op, "R3 opcode", 32'(op_rx), 32'(op));
        chk(adr_rx == exp_a, "R3 address", adr_rx, exp_a);
        // R7: claimed chip select and frame length
        chk(seen_csn == ~(4'b0001 << cs), "R7 cs", 32'(seen_csn), 32'(~(4'b0001 << cs)));
        chk(frames == fr0 + 1 && last_edges == m_hdr + 8*nb/m_lanes, "R7 edges",
            32'(last_edges), 32'(m_hdr + 8*nb/m_lanes));
        // R4: enables during command, address, dummy and data
        chk(oe_bad == 0, "R4 oe", 32'(oe_bad), 32'd0);
    endtask

    task automatic err_read(input logic [ADDR_W-1:0] off, input logic [1:0] lm1, input string req);
        logic [31:0] d;
        logic e;
        int fr0;
        fr0 = frames;
        do_read(off, lm1, 1'b0, d, e);
        chk(e == 1'b1 && d == 32'd0, req, {31'd0, e}, 32'd1);
        chk(frames == fr0, {req, " no frame"}, 32'(frames - fr0), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
        chk(sclk == 1'b0 && rd_valid == 1'b0, "R1 sclk/valid", {30'd0, sclk, rd_valid}, 32'd0);
        chk(rd_ready == 1'b1, "R1 ready", 32'(rd_ready), 32'd1);
        // R10: switch closed at reset
        err_read(24'h000100, 2'd3, "R10");
        // R2: switch opened by write to select 4
        cfg_write(3'd4, 32'd1);
        // directed: single lane, 3 address bytes, no dummy
        good_read(2'd0, 8'h03, 2'd2, 2'd0, 2'd0, 24'h123456, 2'd3);
        // directed: quad, 4 address bytes, 3 dummy bytes
        good_read(2'd3, 8'hEB, 2'd3, 2'd3, 2'd3, 24'hABCDEF, 2'd3);
        // directed: dual, 1 address byte, 1 dummy byte, one byte
        good_read(2'd1, 8'h3B, 2'd0, 2'd1, 2'd1, 24'h0000FE, 2'd0);
        // R5: mode 2 behaves as single lane
        good_read(2'd2, 8'h0B, 2'd1, 2'd1, 2'd2, 24'h00A0B1, 2'd1);
        // R9: read ending exactly at the window edge
        good_read(2'd0, 8'h03, 2'd2, 2'd0, 2'd3, 24'(WIN - 4), 2'd3);
        // R9: one byte past the edge
        err_read(24'(WIN - 3), 2'd3, "R9 edge");
        err_read(24'(WIN - 1), 2'd1, "R9 edge2");
        err_read(24'hFFFFFF, 2'd0, "R9 far");
        // random mix
        for (int t = 0; t < 50; t++) begin
            logic [1:0] lm1;
            lm1 = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                err_read(24'(WIN + $urandom_range(0, 1000)), lm1, "R9 rand");
            end else begin
                good_read(2'($urandom_range(0, 3)), 8'($urandom), 2'($urandom_range(0, 3)),
                          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                          24'($urandom % (WIN - 4)), lm1);
            end
        end
        // R12: setup rewrite after acceptance does not alter the running read
        cfg_write(3'd0, {18'd0, 2'd0, 2'd0, 2'd2, 8'h03});
        cfg_write(3'd5, 32'd0);
        m_nab = 3; m_lanes = 1; m_hdr = 32;
        begin
            logic [31:0] d;
            logic e;
            @(negedge clk);
            rd_req = 1'b1; rd_off = 24'h000040; rd_len_m1 = 2'd1;
            @(negedge clk);
            rd_req = 1'b0;
            cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = {18'd0, 2'd3, 2'd3, 2'd3, 8'hFF};
            @(negedge clk);
            cfg_we = 1'b0;
            while (!rd_valid) @(negedge clk);
            d = rd_data; e = rd_err;
            chk(e == 1'b0 && d == {16'd0, mem_byte(32'h41), mem_byte(32'h40)}, "R12 setup captured",
                d, {16'd0, mem_byte(32'h41), mem_byte(32'h40)});
            chk(op_rx == 8'h03, "R12 opcode", 32'(op_rx), 32'h03);
            @(negedge clk);
        end
        // R10: closing the switch refuses reads again
        cfg_write(3'd4, 32'd0);
        err_read(24'h000010, 2'd0, "R10 closed");
        chk(cs_n == 4'hF && sclk == 1'b0, "R12 idle", {27'd0, cs_n, sclk}, 32'h1E);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule